// File: doc/BRIEF.md
# Ethernet PHY Power-Saving Mode Controller

This block holds a 16-bit power control register and, from its fields, sets the low-power state of an Ethernet PHY. A management write strobe loads the register. The block then drives registered enables for the analog front end and the datapath, an enable for the internal clock gate, and an enable for the energy detector. In one of the sleep modes it also raises a periodic one-cycle request to send a normal link pulse. The management read path stays live in every state, because the register is read back directly.

Power saving is active only while an enable bit is set. A 2-bit field then selects one of four states:
- normal operation;
- IEEE power down, the only state in which the clock-disable bit can stop the internal clocks;
- active sleep, which keeps energy detection on and sends the link-pulse beacon;
- passive sleep, which keeps energy detection on and sends no beacon.

When the line-side energy-detect input rises during either sleep state, the block clears the enable bit itself. The PHY returns to full operation, and management software can see that the wake happened.

The beacon interval is counted from the clock frequency (`CLK_HZ`) and the interval in milliseconds (`BEACON_MS`, 1400 by default). Its length is PERIOD = CLK_HZ/1000*BEACON_MS cycles.

Top module: `phy_pwr_ctrl`

## Requirements
- R1: After a synchronous reset, `rd_data` reads 0x0103. `analog_en`, `datapath_en`, `edet_en` and `clk_en` are 1, and `nlp_req` is 0.
- R2: Only bit 15 (clock disable), bit 14 (power-save enable) and bits 13:12 (mode) are writable. They take `wr_data` at the clock edge where `wr_en` is 1 and can be read on `rd_data` after that edge. All other bits ignore writes and keep their reset value, so 0x0103 & 0x0FFF reads back.
- R3: When bit 14 is 0, the outputs are those of normal operation (all four enables 1, no beacon), whatever the mode field and bit 15 hold.
- R4: With bit 14 = 1 and mode 1 (IEEE power down), `analog_en`, `datapath_en` and `edet_en` are 0, and `clk_en` equals the inverse of bit 15.
- R5: Bit 15 has no effect on `clk_en` in any state other than IEEE power down.
- R6: With bit 14 = 1 and mode 2 (active sleep), `analog_en` and `datapath_en` are 0, while `edet_en` and `clk_en` are 1. `nlp_req` pulses for one cycle every PERIOD cycles. The first pulse appears PERIOD cycles after the active-sleep outputs first appear.
- R7: With bit 14 = 1 and mode 3 (passive sleep), the enables are the same as in R6, but `nlp_req` stays 0.
- R8: If `energy_det` is 1 at a clock edge while the register selects active or passive sleep, bit 14 reads 0 after that edge and the mode field is kept. The outputs return to normal operation one edge later. `energy_det` has no effect in normal operation or in IEEE power down.
- R9: The outputs are registered. They change on the edge after the register changes. `clk_en` changes only on the edge that follows a change of the register.
- R10: Leaving active sleep and entering it again restarts the beacon interval from zero.
- R11: When a write and a wake occur at the same edge, the written value is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Management write strobe |
| wr_data | input | 16 | Management write data |
| energy_det | input | 1 | Line-side energy detected |
| rd_data | output | 16 | Control register read-back |
| analog_en | output | 1 | Analog front-end enable |
| datapath_en | output | 1 | Digital datapath enable |
| edet_en | output | 1 | Energy detector enable |
| clk_en | output | 1 | Internal clock gate enable (1 = running) |
| nlp_req | output | 1 | One-cycle normal-link-pulse request |

## Verification
A vector table sets the register to every combination of enable bit, mode field and clock-disable bit. This separates the four decoded states, shows that the clock-disable bit acts only in power down, and shows that the mode field is ignored while saving is off. Writes with all-ones and all-zeros data show which bits are writable and which are fixed. The beacon is timed for its first pulse, for a steady interval, after leaving and re-entering active sleep, and for its absence in passive sleep. Energy-detect pulses are applied in each state to tell a real wake from no effect, and once together with a write to fix which of the two wins.

// File: rtl/phy_pwr_pkg.sv
package phy_pwr_pkg;
  typedef enum logic [1:0] {
    PM_NORMAL    = 2'd0,
    PM_IEEE_PD   = 2'd1,
    PM_ACT_SLEEP = 2'd2,
    PM_PAS_SLEEP = 2'd3
  } pm_mode_t;

  localparam int          CTRL_W     = 16;
  localparam int          BIT_CLKOFF = 15;
  localparam int          BIT_PSEN   = 14;
  localparam int          MODE_LSB   = 12;
  localparam logic [15:0] CTRL_RESET = 16'h0103;
  localparam logic [15:0] CTRL_WMASK = 16'hF000;
endpackage

// File: rtl/phy_pwr_reg.sv
module phy_pwr_reg
  import phy_pwr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              wake_clr,
  output logic [CTRL_W-1:0] ctrl_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= CTRL_RESET;
    end else if (wr_en) begin
      ctrl_q <= (wr_data & CTRL_WMASK) | (CTRL_RESET & ~CTRL_WMASK);
    end else if (wake_clr) begin
      ctrl_q[BIT_PSEN] <= 1'b0;
    end
  end

  // R2
  wr_fields_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> ((ctrl_q & CTRL_WMASK) == ($past(wr_data) & CTRL_WMASK)));

  // R8
  wake_clears_en_chk: assert property (@(posedge clk) disable iff (rst)
    (wake_clr && !wr_en) |=> !ctrl_q[BIT_PSEN]);
endmodule

// File: rtl/phy_pwr_seq.sv
module phy_pwr_seq
  import phy_pwr_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     clkoff,
  input  logic     psen,
  input  pm_mode_t mode,
  input  logic     energy_det,
  output logic     wake_clr,
  output logic     analog_en,
  output logic     datapath_en,
  output logic     edet_en,
  output logic     clk_en,
  output logic     beacon_en
);
  pm_mode_t eff;
  logic     in_sleep;

  always_comb begin
    eff      = psen ? mode : PM_NORMAL;
    in_sleep = (eff == PM_ACT_SLEEP) || (eff == PM_PAS_SLEEP);
    wake_clr = in_sleep && energy_det;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      analog_en   <= 1'b1;
      datapath_en <= 1'b1;
      edet_en     <= 1'b1;
      clk_en      <= 1'b1;
      beacon_en   <= 1'b0;
    end else begin
      analog_en   <= (eff == PM_NORMAL);
      datapath_en <= (eff == PM_NORMAL);
      edet_en     <= (eff != PM_IEEE_PD);
      clk_en      <= !((eff == PM_IEEE_PD) && clkoff);
      beacon_en   <= (eff == PM_ACT_SLEEP);
    end
  end

  // R4
  clk_off_only_pd_chk: assert property (@(posedge clk) disable iff (rst)
    !clk_en |-> ($past(psen) && ($past(mode) == PM_IEEE_PD)));

  // R9
  clk_gate_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(clk_en) |-> ($past({clkoff, psen, mode}) != $past({clkoff, psen, mode}, 2)));
endmodule

// File: rtl/phy_pwr_beacon.sv
module phy_pwr_beacon #(
  parameter int unsigned CLK_HZ    = 125_000_000,
  parameter int unsigned BEACON_MS = 1400
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic pulse
);
  localparam int unsigned PERIOD = (CLK_HZ / 1000) * BEACON_MS;
  localparam int          CNT_W  = (PERIOD > 1) ? $clog2(PERIOD) : 1;

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt   <= '0;
      pulse <= 1'b0;
    end else if (cnt == CNT_W'(PERIOD - 1)) begin
      cnt   <= '0;
      pulse <= 1'b1;
    end else begin
      cnt   <= cnt + 1'b1;
      pulse <= 1'b0;
    end
  end

  // R6
  pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
    pulse |=> !pulse);

  // R7
  pulse_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
    pulse |-> $past(en));
endmodule

// File: rtl/phy_pwr_ctrl.sv
module phy_pwr_ctrl
  import phy_pwr_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 125_000_000,
  parameter int unsigned BEACON_MS = 1400
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [15:0] wr_data,
  input  logic        energy_det,
  output logic [15:0] rd_data,
  output logic        analog_en,
  output logic        datapath_en,
  output logic        edet_en,
  output logic        clk_en,
  output logic        nlp_req
);
  logic [CTRL_W-1:0] ctrl_q;
  logic              wake_clr;
  logic              beacon_en;

  phy_pwr_reg u_reg (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .wake_clr (wake_clr),
    .ctrl_q   (ctrl_q)
  );

  phy_pwr_seq u_seq (
    .clk         (clk),
    .rst         (rst),
    .clkoff      (ctrl_q[BIT_CLKOFF]),
    .psen        (ctrl_q[BIT_PSEN]),
    .mode        (pm_mode_t'(ctrl_q[MODE_LSB+1:MODE_LSB])),
    .energy_det  (energy_det),
    .wake_clr    (wake_clr),
    .analog_en   (analog_en),
    .datapath_en (datapath_en),
    .edet_en     (edet_en),
    .clk_en      (clk_en),
    .beacon_en   (beacon_en)
  );

  phy_pwr_beacon #(
    .CLK_HZ    (CLK_HZ),
    .BEACON_MS (BEACON_MS)
  ) u_beacon (
    .clk   (clk),
    .rst   (rst),
    .en    (beacon_en),
    .pulse (nlp_req)
  );

  assign rd_data = ctrl_q;

  // R11
  write_beats_wake_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wake_clr) |=> (rd_data[BIT_PSEN] == $past(wr_data[BIT_PSEN])));
endmodule

// File: tb/tb_phy_pwr_ctrl.sv
module tb_phy_pwr_ctrl;
  localparam int unsigned CLK_HZ    = 5000;
  localparam int unsigned BEACON_MS = 1400;
  localparam int          PERIOD    = (CLK_HZ / 1000) * BEACON_MS;
  localparam int          WDOG      = 190_000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        energy_det = 1'b0;
  logic [15:0] rd_data;
  logic        analog_en, datapath_en, edet_en, clk_en, nlp_req;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  phy_pwr_ctrl #(.CLK_HZ(CLK_HZ), .BEACON_MS(BEACON_MS)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .energy_det(energy_det), .rd_data(rd_data), .analog_en(analog_en),
    .datapath_en(datapath_en), .edet_en(edet_en), .clk_en(clk_en),
    .nlp_req(nlp_req)
  );

  always #5 clk = ~clk;

  // write value, {ana, dp, edet, clk} expected
  typedef struct packed {
    logic [15:0] wv;
    logic [3:0]  exp;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{16'h0000, 4'b1111},  // R3 normal
    '{16'h3000, 4'b1111},  // R3 psen=0, mode 3 ignored
    '{16'h9000, 4'b1111},  // R3 psen=0, clkoff+mode1 ignored
    '{16'h4000, 4'b1111},  // R3 psen=1 mode0
    '{16'hC000, 4'b1111},  // R5 clkoff in normal
    '{16'h5000, 4'b0001},  // R4 power down, clocks run
    '{16'hD000, 4'b0000},  // R4 power down, clocks off
    '{16'h6000, 4'b0011},  // R6 active sleep
    '{16'hE000, 4'b0011},  // R5 clkoff in active
    '{16'h7000, 4'b0011},  // R7 passive
    '{16'hF000, 4'b0011},  // R5 clkoff in passive
    '{16'h1000, 4'b1111}   // R3 back to off
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [3:0] outs();
    return {analog_en, datapath_en, edet_en, clk_en};
  endfunction

  task automatic measure_pulse(input string req, input int exp);
    int n = 0;
    while (!nlp_req && n < PERIOD + 10) begin
      @(negedge clk);
      n++;
    end
    check(req, n, exp);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WDOG && !done) begin
      done = 1'b1;
      fails++;
      tests++;
      $display("FAIL watchdog actual=%0d expected<%0d", cycles, WDOG);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    check("R1 rd", rd_data, 16'h0103);
    check("R1 outs", {outs(), nlp_req}, 5'b11110);

    for (int i = 0; i < NV; i++) begin
      wr(VECS[i].wv);
      check("R2 rd", rd_data, VECS[i].wv | 16'h0103);
      @(negedge clk);
      check("R3-R7 table", outs(), VECS[i].exp);
    end

    // R2 reserved bits fixed
    wr(16'hFFFF);
    check("R2 ones", rd_data, 16'hF103);
    wr(16'h0000);
    check("R2 zeros", rd_data, 16'h0103);

    // R9 output latency one edge after register
    wr(16'hD000);
    check("R9 not yet", outs(), 4'b1111);
    @(negedge clk);
    check("R9 applied", outs(), 4'b0000);

    // R8 energy in power down ignored
    energy_det = 1'b1;
    repeat (3) @(negedge clk);
    energy_det = 1'b0;
    check("R8 pd rd", rd_data, 16'hD103);
    check("R8 pd outs", outs(), 4'b0000);

    // R8 energy in normal ignored
    wr(16'h0000);
    energy_det = 1'b1;
    repeat (2) @(negedge clk);
    energy_det = 1'b0;
    check("R8 normal rd", rd_data, 16'h0103);

    // R8 wake from active sleep
    wr(16'h6000);
    @(negedge clk);
    check("R8 act outs", outs(), 4'b0011);
    energy_det = 1'b1;
    @(negedge clk);
    energy_det = 1'b0;
    check("R8 act rd", rd_data, 16'h2103);
    check("R8 act still", outs(), 4'b0011);
    @(negedge clk);
    check("R8 act woke", outs(), 4'b1111);

    // R8 wake from passive sleep
    wr(16'h7000);
    @(negedge clk);
    energy_det = 1'b1;
    @(negedge clk);
    energy_det = 1'b0;
    check("R8 pas rd", rd_data, 16'h3103);
    @(negedge clk);
    check("R8 pas woke", outs(), 4'b1111);

    // R11 write and wake at same edge
    wr(16'h6000);
    @(negedge clk);
    energy_det = 1'b1;
    wr_en = 1'b1;
    wr_data = 16'h7000;
    @(negedge clk);
    wr_en = 1'b0;
    energy_det = 1'b0;
    check("R11 rd", rd_data, 16'h7103);
    @(negedge clk);
    check("R11 outs", outs(), 4'b0011);

    // R6 beacon timing
    wr(16'h0000);
    @(negedge clk);
    wr(16'h6000);
    @(negedge clk);
    check("R6 entry", outs(), 4'b0011);
    measure_pulse("R6 first", PERIOD);
    @(negedge clk);
    check("R6 one cycle", nlp_req, 1'b0);
    measure_pulse("R6 interval", PERIOD - 1);

    // R10 restart after leave/re-enter
    repeat (PERIOD / 2) @(negedge clk);
    wr(16'h0000);
    repeat (4) @(negedge clk);
    wr(16'h6000);
    @(negedge clk);
    measure_pulse("R10 restart", PERIOD);

    // R7 passive: no pulse over more than two intervals
    wr(16'h7000);
    begin
      int seen = 0;
      for (int k = 0; k < 2 * PERIOD + 5; k++) begin
        @(negedge clk);
        if (nlp_req) seen++;
      end
      check("R7 no pulse", seen, 0);
    end

    // R1 reset again restores state
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 re-reset", {rd_data, outs(), nlp_req}, {16'h0103, 5'b11110});

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule